// File: doc/BRIEF.md
# Operand-Fetch Bypass and Interlock Stage

This block is the operand-fetch stage of a five-stage in-order pipeline (fetch, decode, operand fetch, execute, write-back). It holds the general register file and, for each of the two source operands of the instruction now in operand fetch, picks the value to pass to execute. That value is either the register file read, the result sitting in write-back, or the result the execute stage is producing in this very cycle, which is fed back on a combinational wire. All comparisons and multiplexing are done here, in operand fetch, so that the execute stage carries no forwarding logic.

When forwarding cannot supply a value, the stage raises a stall. The fetch, decode and operand-fetch stages then hold, and a bubble enters execute. A build parameter picks one of three policies: interlock only, forward from write-back only, or forward from both write-back and execute. The block also carries the execute and write-back stage tags (destination index and write code) and the write-back data. The arithmetic unit outside the block returns its result on `ex_result`, and the block commits that result to the register file from write-back.

Top module: `opf_bypass`

## Requirements
- R1: After reset, `ex_valid` is 0, `ex_wcode` is 0, `ex_op_a` and `ex_op_b` are 0, and the register file holds 0 in every entry.
- R2: Write codes are 2 bits: 0 = no write, 1 = general-register write, 2 = other (non-register) write. Only code 1 in write-back updates the register file. The update is visible to a plain register read from the next cycle. Codes 0 and 2 leave the addressed register unchanged.
- R3: With `MODE`=2, an operand whose index matches the destination of a code-1 instruction in execute receives `ex_result` of that cycle, with no stall.
- R4: With `MODE`=1 or 2, an operand whose index matches the destination of a code-1 instruction in write-back receives that write-back value in the same cycle.
- R5: With `MODE`=2, when the execute and write-back instructions both write the matched register, the execute result is used.
- R6: With `MODE`=0, a code-1 destination in execute or in write-back that matches either source index raises `stall_front`. In the next cycle execute holds a bubble (`ex_valid`=0, `ex_wcode`=0).
- R7: With `MODE`=1, `stall_front` is raised only for a match against a code-1 instruction in execute. The stalled instruction then proceeds one cycle later with the value forwarded from write-back.
- R8: With `MODE`=2, `stall_front` is never raised.
- R9: An instruction accepted (`op_valid`=1, `stall_front`=0) appears at the next cycle on `ex_valid`, `ex_dst`, `ex_wcode` and the two operand outputs.
- R10: `stall_front` is 0 whenever `op_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is present in operand fetch |
| op_src_a | input | 4 | First source register index |
| op_src_b | input | 4 | Second source register index |
| op_dst | input | 4 | Destination register index |
| op_wcode | input | 2 | Write code of the instruction (0 none, 1 register, 2 other) |
| ex_result | input | 32 | Result computed by execute this cycle |
| stall_front | output | 1 | Hold fetch, decode and operand fetch this cycle |
| ex_valid | output | 1 | Execute holds a real instruction |
| ex_op_a | output | 32 | First operand presented to execute |
| ex_op_b | output | 32 | Second operand presented to execute |
| ex_dst | output | 4 | Destination index in execute |
| ex_wcode | output | 2 | Write code in execute |

## Verification
Two things can fall in one cycle. The first is the write-back register commit and an operand-fetch read of that same index. The second is the case where the execute and write-back results both target the register being read. Back-to-back instruction streams that write one register twice and then read it provoke both. The bench runs these streams under all three policies. A scoreboard, built from an in-order register model, predicts every operand that reaches execute. A cycle shadow of the execute and write-back tags predicts each stall, so a stale, early or wrongly prioritised value shows up as an operand miscompare, and a missing or extra interlock shows up as a stall mismatch.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [1:0] {
        WC_NONE  = 2'd0,
        WC_GPR   = 2'd1,
        WC_OTHER = 2'd2
    } wcode_e;

    localparam int MODE_INTERLOCK = 0;
    localparam int MODE_WB_FWD    = 1;
    localparam int MODE_FULL_FWD  = 2;

    localparam int N_SRC = 2;

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
    parameter int DATA_W   = 32,
    parameter int REGS     = 16,
    parameter int RD_PORTS = 2,
    localparam int IDX_W   = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx  [RD_PORTS],
    output logic [DATA_W-1:0] rd_data [RD_PORTS]
);

    logic [DATA_W-1:0] regs_q [REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data[p] = regs_q[rd_idx[p]];
    end

endmodule

// File: rtl/opf_hazard.sv
module opf_hazard
    import opf_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int MODE  = MODE_FULL_FWD
) (
    input  logic             op_valid,
    input  logic [IDX_W-1:0] src_idx [N_SRC],
    input  logic [IDX_W-1:0] ex_dst,
    input  wcode_e           ex_code,
    input  logic [IDX_W-1:0] wb_dst,
    input  wcode_e           wb_code,
    output logic [N_SRC-1:0] ex_hit,
    output logic [N_SRC-1:0] wb_hit,
    output logic             stall
);

    for (genvar s = 0; s < N_SRC; s++) begin : g_cmp
        assign ex_hit[s] = (ex_code == WC_GPR) && (ex_dst == src_idx[s]);
        assign wb_hit[s] = (wb_code == WC_GPR) && (wb_dst == src_idx[s]);
    end

    if (MODE == MODE_INTERLOCK) begin : g_stall_any
        assign stall = op_valid && ((|ex_hit) || (|wb_hit));
    end else if (MODE == MODE_WB_FWD) begin : g_stall_ex
        assign stall = op_valid && (|ex_hit);
    end else begin : g_stall_none
        assign stall = 1'b0;
    end

endmodule

// File: rtl/opf_src_mux.sv
module opf_src_mux
    import opf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE   = MODE_FULL_FWD
) (
    input  logic              ex_hit,
    input  logic              wb_hit,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] ex_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] operand
);

    if (MODE == MODE_FULL_FWD) begin : g_full
        // the instruction in execute is newer than the one in write-back
        always_comb begin
            if (ex_hit)      operand = ex_val;
            else if (wb_hit) operand = wb_val;
            else             operand = rf_val;
        end
    end else if (MODE == MODE_WB_FWD) begin : g_wb
        logic ex_unused;
        logic [DATA_W-1:0] exv_unused;
        assign ex_unused  = ex_hit;
        assign exv_unused = ex_val;
        assign operand    = wb_hit ? wb_val : rf_val;
    end else begin : g_none
        logic ex_unused, wb_unused;
        logic [DATA_W-1:0] exv_unused, wbv_unused;
        assign ex_unused  = ex_hit;
        assign wb_unused  = wb_hit;
        assign exv_unused = ex_val;
        assign wbv_unused = wb_val;
        assign operand    = rf_val;
    end

endmodule

// File: rtl/opf_bypass.sv
module opf_bypass
    import opf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REGS   = 16,
    parameter int MODE   = MODE_FULL_FWD,
    localparam int IDX_W = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [IDX_W-1:0]  op_src_a,
    input  logic [IDX_W-1:0]  op_src_b,
    input  logic [IDX_W-1:0]  op_dst,
    input  logic [1:0]        op_wcode,
    input  logic [DATA_W-1:0] ex_result,
    output logic              stall_front,
    output logic              ex_valid,
    output logic [DATA_W-1:0] ex_op_a,
    output logic [DATA_W-1:0] ex_op_b,
    output logic [IDX_W-1:0]  ex_dst,
    output logic [1:0]        ex_wcode
);

    typedef struct packed {
        logic              ex_valid;
        logic [IDX_W-1:0]  ex_dst;
        wcode_e            ex_code;
        logic [DATA_W-1:0] ex_a;
        logic [DATA_W-1:0] ex_b;
        logic [IDX_W-1:0]  wb_dst;
        wcode_e            wb_code;
        logic [DATA_W-1:0] wb_data;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [IDX_W-1:0]  src_idx [N_SRC];
    logic [DATA_W-1:0] rf_val  [N_SRC];
    logic [DATA_W-1:0] opnd    [N_SRC];
    logic [N_SRC-1:0]  ex_hit, wb_hit;
    logic              stall;

    assign src_idx[0] = op_src_a;
    assign src_idx[1] = op_src_b;

    opf_regfile #(
        .DATA_W  (DATA_W),
        .REGS    (REGS),
        .RD_PORTS(N_SRC)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (st_q.wb_code == WC_GPR),
        .wr_idx (st_q.wb_dst),
        .wr_data(st_q.wb_data),
        .rd_idx (src_idx),
        .rd_data(rf_val)
    );

    opf_hazard #(
        .IDX_W(IDX_W),
        .MODE (MODE)
    ) u_haz (
        .op_valid(op_valid),
        .src_idx (src_idx),
        .ex_dst  (st_q.ex_dst),
        .ex_code (st_q.ex_code),
        .wb_dst  (st_q.wb_dst),
        .wb_code (st_q.wb_code),
        .ex_hit  (ex_hit),
        .wb_hit  (wb_hit),
        .stall   (stall)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        opf_src_mux #(
            .DATA_W(DATA_W),
            .MODE  (MODE)
        ) u_mux (
            .ex_hit (ex_hit[s]),
            .wb_hit (wb_hit[s]),
            .rf_val (rf_val[s]),
            .ex_val (ex_result),
            .wb_val (st_q.wb_data),
            .operand(opnd[s])
        );
    end

    always_comb begin
        st_d = st_q;
        // execute advances into write-back every cycle
        st_d.wb_dst  = st_q.ex_dst;
        st_d.wb_code = st_q.ex_code;
        st_d.wb_data = ex_result;
        if (op_valid && !stall) begin
            st_d.ex_valid = 1'b1;
            st_d.ex_dst   = op_dst;
            st_d.ex_code  = wcode_e'(op_wcode);
            st_d.ex_a     = opnd[0];
            st_d.ex_b     = opnd[1];
        end else begin
            st_d.ex_valid = 1'b0;
            st_d.ex_code  = WC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_front = stall;
    assign ex_valid    = st_q.ex_valid;
    assign ex_op_a     = st_q.ex_a;
    assign ex_op_b     = st_q.ex_b;
    assign ex_dst      = st_q.ex_dst;
    assign ex_wcode    = st_q.ex_code;

endmodule

// File: rtl/opf_bypass_checker.sv
module opf_bypass_checker #(
    parameter int IDX_W = 4,
    parameter int MODE  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [IDX_W-1:0] op_src_a,
    input logic [IDX_W-1:0] op_src_b,
    input logic [IDX_W-1:0] op_dst,
    input logic [1:0]       op_wcode,
    input logic             stall_front,
    input logic             ex_valid,
    input logic [IDX_W-1:0] ex_dst,
    input logic [1:0]       ex_wcode
);

    assert_idle_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !stall_front);

    assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |=> (!ex_valid && ex_wcode == 2'd0));

    assert_full_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != 2) || !stall_front);

    assert_wb_mode_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == 1 && stall_front) |->
            (ex_wcode == 2'd1 && (ex_dst == op_src_a || ex_dst == op_src_b)));

    assert_accept_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !stall_front) |=>
            (ex_valid && ex_dst == $past(op_dst) && ex_wcode == $past(op_wcode)));

endmodule

bind opf_bypass opf_bypass_checker #(
    .IDX_W(IDX_W),
    .MODE (MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_src_a   (op_src_a),
    .op_src_b   (op_src_b),
    .op_dst     (op_dst),
    .op_wcode   (op_wcode),
    .stall_front(stall_front),
    .ex_valid   (ex_valid),
    .ex_dst     (ex_dst),
    .ex_wcode   (ex_wcode)
);

// File: tb/opf_bypass_lane.sv
module opf_bypass_lane #(
    parameter int MODE = 2
) (
    input logic clk,
    input logic rst_n
);

    logic        op_valid = 1'b0;
    logic [3:0]  op_src_a = '0, op_src_b = '0, op_dst = '0;
    logic [1:0]  op_wcode = '0;
    logic [31:0] ex_result;
    logic        stall_front, ex_valid;
    logic [31:0] ex_op_a, ex_op_b;
    logic [3:0]  ex_dst;
    logic [1:0]  ex_wcode;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // stand-in for the execute unit
    assign ex_result = ex_op_a + ex_op_b + 32'd1;

    opf_bypass #(.MODE(MODE)) u_opf_bypass (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
        .op_wcode(op_wcode), .ex_result(ex_result), .stall_front(stall_front),
        .ex_valid(ex_valid), .ex_op_a(ex_op_a), .ex_op_b(ex_op_b),
        .ex_dst(ex_dst), .ex_wcode(ex_wcode)
    );

    // reference state
    logic [31:0] arch [16];
    int sh_ex_code = 0, sh_ex_dst = 0, sh_wb_code = 0, sh_wb_dst = 0;
    int p1_dst = -1, p2_dst = -1;

    logic [31:0] q_a [$];
    logic [31:0] q_b [$];
    logic [3:0]  q_dst [$];
    logic [1:0]  q_code [$];
    string       q_tag [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s mode%0d %s: actual %h expected %h", req, MODE, what, act, exp);
        end
    endtask

    function automatic string stall_req();
        if (MODE == 0) return "R6";
        if (MODE == 1) return "R7";
        return "R8";
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            #1;
            check(stall_front == 1'b0, "R10", "stall while idle", {31'd0, stall_front}, 32'd0);
            @(posedge clk);
            sh_wb_code = sh_ex_code; sh_wb_dst = sh_ex_dst; sh_ex_code = 0;
            p2_dst = p1_dst; p1_dst = -1;
        end
    endtask

    task automatic issue(input int a, input int b, input int d, input int c);
        bit pred, hx, hw;
        logic [31:0] va, vb;
        string tag;
        @(negedge clk);
        op_valid = 1'b1;
        op_src_a = 4'(a); op_src_b = 4'(b); op_dst = 4'(d); op_wcode = 2'(c);
        forever begin
            #1;
            hx = (sh_ex_code == 1) && (sh_ex_dst == a || sh_ex_dst == b);
            hw = (sh_wb_code == 1) && (sh_wb_dst == a || sh_wb_dst == b);
            pred = (MODE == 0) ? (hx || hw) : (MODE == 1) ? hx : 1'b0;
            check(stall_front == pred, stall_req(), "stall", {31'd0, stall_front}, {31'd0, pred});
            @(posedge clk);
            sh_wb_code = sh_ex_code; sh_wb_dst = sh_ex_dst;
            if (pred) begin
                sh_ex_code = 0;
                p2_dst = p1_dst; p1_dst = -1;
                @(negedge clk);
            end else begin
                sh_ex_code = c; sh_ex_dst = d;
                break;
            end
        end
        va = arch[a]; vb = arch[b];
        if ((p1_dst == a || p1_dst == b) && (p2_dst == a || p2_dst == b) && p1_dst == p2_dst) tag = "R5";
        else if (p1_dst == a || p1_dst == b) tag = "R3";
        else if (p2_dst == a || p2_dst == b) tag = "R4";
        else tag = "R2";
        q_a.push_back(va); q_b.push_back(vb);
        q_dst.push_back(4'(d)); q_code.push_back(2'(c)); q_tag.push_back(tag);
        if (c == 1) arch[d] = va + vb + 32'd1;
        p2_dst = p1_dst;
        p1_dst = (c == 1) ? d : -1;
    endtask

    // monitor: compare every instruction that reaches execute
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (ex_valid) begin
                if (q_a.size() == 0) begin
                    check(1'b0, "R9", "unexpected instruction", 32'd1, 32'd0);
                end else begin
                    automatic string t = q_tag.pop_front();
                    automatic logic [31:0] ea = q_a.pop_front();
                    automatic logic [31:0] eb = q_b.pop_front();
                    automatic logic [3:0]  ed = q_dst.pop_front();
                    automatic logic [1:0]  ec = q_code.pop_front();
                    check(ex_op_a == ea, t, "operand a", ex_op_a, ea);
                    check(ex_op_b == eb, t, "operand b", ex_op_b, eb);
                    check(ex_dst == ed && ex_wcode == ec, "R9", "dst/code",
                          {26'd0, ex_dst, ex_wcode}, {26'd0, ed, ec});
                end
            end else begin
                check(ex_wcode == 2'd0, "R6", "bubble code", {30'd0, ex_wcode}, 32'd0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) arch[i] = '0;
        @(posedge rst_n);
        @(negedge clk);
        // R1: reset state
        check(ex_valid == 1'b0, "R1", "ex_valid", {31'd0, ex_valid}, 32'd0);
        check(ex_wcode == 2'd0, "R1", "ex_wcode", {30'd0, ex_wcode}, 32'd0);
        check(ex_op_a == 32'd0 && ex_op_b == 32'd0, "R1", "operands", ex_op_a | ex_op_b, 32'd0);
        check(stall_front == 1'b0, "R1", "stall", {31'd0, stall_front}, 32'd0);
        // dependency chains, R3/R4/R5
        issue(0, 0, 1, 1);
        issue(1, 1, 2, 1);
        issue(1, 2, 3, 1);
        issue(2, 2, 3, 1);
        issue(3, 3, 4, 1);
        // R2: code 2 and code 0 write nothing
        issue(4, 1, 5, 2);
        idle(3);
        issue(5, 4, 6, 1);
        issue(6, 0, 7, 0);
        issue(7, 6, 8, 1);
        idle(2);
        // R2: same-cycle commit and read after gap of one
        issue(8, 8, 9, 1);
        idle(1);
        issue(9, 0, 10, 1);
        for (int i = 0; i < 24; i++) begin
            issue(i % 16, (i * 7) % 16, (i % 15) + 1, (i % 5 == 4) ? 2 : 1);
            if (i % 6 == 5) idle(i % 3);
        end
        idle(4);
        check(q_a.size() == 0, "R9", "pending items", q_a.size(), 32'd0);
        done = 1;
    end

endmodule

// File: tb/opf_bypass_bench.sv
module opf_bypass_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #5 clk = ~clk;

    opf_bypass_lane #(.MODE(0)) u_lane_il (.clk(clk), .rst_n(rst_n));
    opf_bypass_lane #(.MODE(1)) u_lane_wb (.clk(clk), .rst_n(rst_n));
    opf_bypass_lane #(.MODE(2)) u_lane_fw (.clk(clk), .rst_n(rst_n));

    int cycles = 0;
    bit timed_out = 0;

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        while (!(u_lane_il.done && u_lane_wb.done && u_lane_fw.done) && cycles < 20000)
            @(posedge clk);
        if (!(u_lane_il.done && u_lane_wb.done && u_lane_fw.done)) begin
            timed_out = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==",
                 u_lane_il.n_chk + u_lane_wb.n_chk + u_lane_fw.n_chk + (timed_out ? 1 : 0),
                 u_lane_il.n_bad + u_lane_wb.n_bad + u_lane_fw.n_bad + (timed_out ? 1 : 0));
        $finish;
    end

endmodule